// File: doc/BRIEF.md
# SDR SDRAM Data Pipeline

This block is the data side of a single-data-rate SDRAM controller. The controller core tells it, one cycle at a time, when a read, write or burst-terminating command (precharge or burst stop) goes out on the command pins, together with the burst-length code that was programmed into the memory's mode register. From those strobes the block works out which clock cycles carry a data beat. For write beats it drives the 16-bit data bus, its output enable and the two byte-mask pins. For read beats it times the byte-mask pins so that the memory blanks the right halves, and it captures the returned data in the cycle that matches the programmed CAS latency of 2 or 3.

With every beat the core supplies a two-bit byte mask. The block applies it with the latency each direction needs. On a write the mask sits on the mask pins in the same cycle as the data. On a read it must reach the memory two clocks before the beat is captured. Captured read halves that were masked are forced to zero.

A new read or write may cut into a running burst on any cycle. A terminating command suppresses all further beats, so the read data stops exactly where the memory's outputs go high-impedance. A marker flags the last captured beat of each run of read beats.

Top module: `sdr_data_pipe`

## Requirements
- R1: While reset is asserted and after it is released with no command, dq_oe, dqm_out, rd_valid, rd_last and rd_data are all zero.
- R2: A write beat sampled at clock edge n drives dq_oe high and dq_out equal to that cycle's wr_data after edge n, for exactly one cycle per beat.
- R3: A write beat sampled at edge n drives dqm_out equal to that cycle's beat_mask after edge n. Bit 1 covers DQ[15:8] and bit 0 covers DQ[7:0].
- R4: A read beat sampled at edge n makes the block sample dq_in at edge n+1+L and raise rd_valid after that edge. L is 3 when cas_lat3 is 1 and 2 when it is 0.
- R5: For a read beat sampled at edge n, dqm_out carries its mask after edge n+L-2, which is two clocks ahead of the capture edge. If a write beat drives the mask pins in the same cycle, the write mask takes precedence. In a cycle with neither, dqm_out is zero.
- R6: In a captured read beat, each half whose mask bit was set in the beat's cycle reads as zero. The other half carries dq_in.
- R7: bl_code selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a burst that runs until interrupted. The codes 4, 5 and 6 give 1 beat. The code is taken only in the command cycle.
- R8: A read or write command starts a new burst in any cycle, including the cycle right after another command. A beat is issued in the command cycle itself. If read and write arrive together the write wins, and either one wins over a terminating command.
- R9: A terminating command in a cycle with no read or write ends the burst, and no beat is issued in that cycle or afterwards. Read beats issued before it are still captured.
- R10: rd_last is high together with rd_valid when no read beat follows in the next cycle.
- R11: dq_oe is low after every edge at which no write beat was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cas_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects 2; changed only when idle |
| bl_code | input | 3 | Burst-length code sampled with a read or write command |
| rd_cmd | input | 1 | Read command goes out this cycle |
| wr_cmd | input | 1 | Write command goes out this cycle |
| stop_cmd | input | 1 | Precharge or burst stop goes out this cycle |
| beat_mask | input | 2 | Byte mask for this cycle's beat (bit 1 upper, bit 0 lower) |
| wr_data | input | 16 | Write data for this cycle's write beat |
| dq_in | input | 16 | Data bus as driven by the memory |
| dq_out | output | 16 | Data bus value driven towards the memory |
| dq_oe | output | 1 | Data bus output enable |
| dqm_out | output | 2 | Byte-mask pins (bit 1 upper, bit 0 lower) |
| rd_valid | output | 1 | rd_data holds a captured read beat |
| rd_last | output | 1 | Captured beat is the last of its run |
| rd_data | output | 16 | Captured read data with masked halves zeroed |

## Verification
Write bursts with a different mask on every beat separate the zero-delay write mask from the read mask, which is two clocks early. Reads with masks of 1, 2 and 3 on neighbouring beats show which half was blanked and whether the mask lined up with the right beat. Every directed and random pattern runs once at each CAS latency, which tells a capture tap that is one stage off from a correct one. Bursts cut by a terminating command, back-to-back reads, read-versus-write collisions, endless bursts and reserved length codes exercise the priority order, the point at which data stops and the placement of the last-beat marker.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

  localparam int BL_CNT_W = 4;
  localparam int CL_MIN   = 2;
  localparam int CL_MAX   = 3;
  localparam int MASK_W   = 2;

  typedef logic [BL_CNT_W-1:0] beat_cnt_t;

  typedef enum logic [1:0] {
    BURST_IDLE = 2'd0,
    BURST_RD   = 2'd1,
    BURST_WR   = 2'd2
  } burst_mode_e;

  function automatic beat_cnt_t burst_beats(input logic [2:0] code);
    case (code)
      3'd1:    return beat_cnt_t'(2);
      3'd2:    return beat_cnt_t'(4);
      3'd3:    return beat_cnt_t'(8);
      default: return beat_cnt_t'(1);
    endcase
  endfunction

  function automatic logic burst_is_page(input logic [2:0] code);
    return code == 3'b111;
  endfunction

endpackage

// File: rtl/sdr_burst_track.sv
module sdr_burst_track
  import sdr_dp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_cmd,
  input  logic       wr_cmd,
  input  logic       stop_cmd,
  input  logic [2:0] bl_code,
  output logic       rd_beat,
  output logic       wr_beat
);

  localparam beat_cnt_t ONE = beat_cnt_t'(1);

  burst_mode_e mode_q, mode_d;
  beat_cnt_t   rem_q, rem_d;
  logic        page_q, page_d;
  beat_cnt_t   cmd_len;
  logic        cmd_page;

  assign cmd_len  = burst_beats(bl_code);
  assign cmd_page = burst_is_page(bl_code);

  always_comb begin
    mode_d  = mode_q;
    rem_d   = rem_q;
    page_d  = page_q;
    rd_beat = 1'b0;
    wr_beat = 1'b0;
    if (wr_cmd) begin
      wr_beat = 1'b1;
      mode_d  = BURST_WR;
      rem_d   = cmd_len - ONE;
      page_d  = cmd_page;
    end else if (rd_cmd) begin
      rd_beat = 1'b1;
      mode_d  = BURST_RD;
      rem_d   = cmd_len - ONE;
      page_d  = cmd_page;
    end else if (stop_cmd) begin
      mode_d  = BURST_IDLE;
      rem_d   = '0;
      page_d  = 1'b0;
    end else if (mode_q != BURST_IDLE) begin
      if (page_q || (rem_q != '0)) begin
        rd_beat = (mode_q == BURST_RD);
        wr_beat = (mode_q == BURST_WR);
        if (!page_q) begin
          rem_d = rem_q - ONE;
        end
      end else begin
        mode_d = BURST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= BURST_IDLE;
      rem_q  <= '0;
      page_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rem_q  <= rem_d;
      page_q <= page_d;
    end
  end

  // R7
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= beat_cnt_t'(7));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BURST_IDLE && !rd_cmd && !wr_cmd) |-> !(rd_beat || wr_beat));

  // R8
  new_cmd_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd || wr_cmd) |=> (mode_q != BURST_IDLE));

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe
  import sdr_dp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_lat3,
  input  logic              rd_beat,
  input  logic [MASK_W-1:0] beat_mask,
  input  logic [DW-1:0]     dq_in,
  output logic [MASK_W-1:0] rd_dqm,
  output logic              rd_valid,
  output logic              rd_last,
  output logic [DW-1:0]     rd_data
);

  localparam int DEPTH = CL_MAX + 1;
  localparam int HALF  = DW / MASK_W;

  logic [DEPTH-1:0]             v_q, v_d;
  logic [DEPTH-1:0][MASK_W-1:0] m_q, m_d;
  logic                         cap_v, cap_nxt;
  logic [MASK_W-1:0]            cap_m;
  logic [DW-1:0]                data_d;
  logic                         valid_q, last_q;
  logic [DW-1:0]                data_q;

  always_comb begin
    v_d[0] = rd_beat;
    m_d[0] = rd_beat ? beat_mask : '0;
    for (int i = 1; i < DEPTH; i++) begin
      v_d[i] = v_q[i-1];
      m_d[i] = m_q[i-1];
    end
  end

  assign cap_v   = cas_lat3 ? v_q[CL_MAX]   : v_q[CL_MIN];
  assign cap_nxt = cas_lat3 ? v_q[CL_MAX-1] : v_q[CL_MIN-1];
  assign cap_m   = cas_lat3 ? m_q[CL_MAX]   : m_q[CL_MIN];

  for (genvar h = 0; h < MASK_W; h++) begin : g_half
    assign data_d[h*HALF +: HALF] = cap_m[h] ? '0 : dq_in[h*HALF +: HALF];
  end

  assign rd_dqm = cas_lat3 ? m_q[0] : (rd_beat ? beat_mask : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= '0;
      m_q     <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      v_q     <= v_d;
      m_q     <= m_d;
      valid_q <= cap_v;
      last_q  <= cap_v & ~cap_nxt;
      if (cap_v) begin
        data_q <= data_d;
      end
    end
  end

  assign rd_valid = valid_q;
  assign rd_last  = last_q;
  assign rd_data  = data_q;

  // R10
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

endmodule

// File: rtl/sdr_wr_drive.sv
module sdr_wr_drive
  import sdr_dp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_beat,
  input  logic [MASK_W-1:0] beat_mask,
  input  logic [DW-1:0]     wr_data,
  input  logic [MASK_W-1:0] rd_dqm,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  output logic [MASK_W-1:0] dqm_out
);

  logic [DW-1:0]     dout_q, dout_d;
  logic              oe_q, oe_d;
  logic [MASK_W-1:0] dqm_q, dqm_d;

  always_comb begin
    oe_d   = wr_beat;
    dout_d = wr_beat ? wr_data : dout_q;
    dqm_d  = wr_beat ? beat_mask : rd_dqm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
      dqm_q  <= '0;
    end else begin
      dout_q <= dout_d;
      oe_q   <= oe_d;
      dqm_q  <= dqm_d;
    end
  end

  assign dq_out  = dout_q;
  assign dq_oe   = oe_q;
  assign dqm_out = dqm_q;

  // R2
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat |=> (dq_oe && dq_out == $past(wr_data)));

  // R3
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat |=> (dqm_out == $past(beat_mask)));

  // R11
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_beat |=> !dq_oe);

endmodule

// File: rtl/sdr_data_pipe.sv
module sdr_data_pipe
  import sdr_dp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_lat3,
  input  logic [2:0]        bl_code,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic              stop_cmd,
  input  logic [MASK_W-1:0] beat_mask,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     dq_in,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  output logic [MASK_W-1:0] dqm_out,
  output logic              rd_valid,
  output logic              rd_last,
  output logic [DW-1:0]     rd_data
);

  localparam int HALF = DW / MASK_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              rd_beat, wr_beat;
  logic [MASK_W-1:0] rd_dqm;
  logic              stop_only;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];
  assign stop_only = stop_cmd & ~rd_cmd & ~wr_cmd;

  sdr_burst_track u_track (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_cmd   (rd_cmd),
    .wr_cmd   (wr_cmd),
    .stop_cmd (stop_cmd),
    .bl_code  (bl_code),
    .rd_beat  (rd_beat),
    .wr_beat  (wr_beat)
  );

  sdr_rd_pipe #(.DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cas_lat3  (cas_lat3),
    .rd_beat   (rd_beat),
    .beat_mask (beat_mask),
    .dq_in     (dq_in),
    .rd_dqm    (rd_dqm),
    .rd_valid  (rd_valid),
    .rd_last   (rd_last),
    .rd_data   (rd_data)
  );

  sdr_wr_drive #(.DW(DW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_beat   (wr_beat),
    .beat_mask (beat_mask),
    .wr_data   (wr_data),
    .rd_dqm    (rd_dqm),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .dqm_out   (dqm_out)
  );

  // R4
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid |-> (cas_lat3 ? $past(rd_beat, 5) : $past(rd_beat, 4)));

  // R6
  rd_upper_mask_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_valid && (cas_lat3 ? $past(beat_mask[1], 5) : $past(beat_mask[1], 4)))
      |-> (rd_data[DW-1:HALF] == '0));

  // R9
  stop_cut_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cas_lat3 ? $past(stop_only, 5) : $past(stop_only, 4)) |-> !rd_valid);

  // R5
  rd_mask_cl2_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_beat && !wr_beat && !cas_lat3) |=> (dqm_out == $past(beat_mask)));

endmodule

// File: tb/sdr_data_pipe_test.sv
`timescale 1ns/1ps
module sdr_data_pipe_test;

  logic        clk;
  logic        rst_n;
  logic        cas_lat3;
  logic [2:0]  bl_code;
  logic        rd_cmd, wr_cmd, stop_cmd;
  logic [1:0]  beat_mask;
  logic [15:0] wr_data, dq_in;
  logic [15:0] dq_out, rd_data;
  logic        dq_oe, rd_valid, rd_last;
  logic [1:0]  dqm_out;

  sdr_data_pipe uut (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3), .bl_code(bl_code),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .stop_cmd(stop_cmd),
    .beat_mask(beat_mask), .wr_data(wr_data), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .dqm_out(dqm_out),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    nchk = 0;
  int    nfail = 0;
  int    k = 0;
  int    cl = 2;
  bit    done = 0;
  string focus = "none";

  logic        riss [16];
  logic        wiss [16];
  logic [1:0]  msk  [16];
  logic [15:0] wdat [16];
  int          m_mode = 0;
  int          m_rem = 0;
  bit          m_page = 0;

  function automatic logic [15:0] pat(input int n);
    return 16'(n * 40503 + 4660);
  endfunction

  function automatic int bl_beats(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic cmp(input string rq, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s [%s] edge %0d: actual %h expected %h", rq, focus, k, act, exp);
    end
  endtask

  task automatic chk(input int e);
    int i, n;
    logic ev, el;
    logic [1:0] rdq;
    logic [15:0] ed;
    i = e % 16;
    if (wiss[i]) begin
      cmp("R2 oe", {15'b0, dq_oe}, 16'd1);
      cmp("R2 data", dq_out, wdat[i]);
      cmp("R3 write mask", {14'b0, dqm_out}, {14'b0, msk[i]});
    end else begin
      cmp("R11 oe idle", {15'b0, dq_oe}, 16'd0);
      if (cl == 2) rdq = riss[i] ? msk[i] : 2'b00;
      else rdq = (e >= 1 && riss[(e-1) % 16]) ? msk[(e-1) % 16] : 2'b00;
      cmp("R5 read mask", {14'b0, dqm_out}, {14'b0, rdq});
    end
    n = e - 1 - cl;
    ev = (n >= 0) && riss[n % 16];
    el = ev && !riss[(n+1) % 16];
    cmp("R4 valid", {15'b0, rd_valid}, {15'b0, ev});
    cmp("R10 last", {15'b0, rd_last}, {15'b0, el});
    if (ev) begin
      ed = pat(n);
      if (msk[n % 16][1]) ed[15:8] = 8'h00;
      if (msk[n % 16][0]) ed[7:0] = 8'h00;
      cmp("R6 read data", rd_data, ed);
    end
  endtask

  task automatic drive(input bit rd, input bit wr, input bit stp,
                       input logic [2:0] bl, input logic [1:0] mk, input logic [15:0] wd);
    bit rb, wb;
    int i, n;
    logic [15:0] dv;
    rb = 0; wb = 0;
    if (wr) begin
      wb = 1; m_mode = 2; m_rem = bl_beats(bl) - 1; m_page = (bl == 3'd7);
    end else if (rd) begin
      rb = 1; m_mode = 1; m_rem = bl_beats(bl) - 1; m_page = (bl == 3'd7);
    end else if (stp) begin
      m_mode = 0; m_rem = 0; m_page = 0;
    end else if (m_mode != 0 && (m_page || m_rem > 0)) begin
      rb = (m_mode == 1); wb = (m_mode == 2);
      if (!m_page) m_rem--;
    end
    i = k % 16;
    riss[i] = rb; wiss[i] = wb; msk[i] = mk; wdat[i] = wd;
    n = k - 1 - cl;
    if (n >= 0 && riss[n % 16]) begin
      dv = pat(n);
      if (msk[n % 16][1]) dv[15:8] = 8'hEE;
      if (msk[n % 16][0]) dv[7:0] = 8'hEE;
    end else begin
      dv = 16'hC3C3;
    end
    rd_cmd = rd; wr_cmd = wr; stop_cmd = stp;
    bl_code = bl; beat_mask = mk; wr_data = wd; dq_in = dv;
  endtask

  task automatic step(input bit rd, input bit wr, input bit stp,
                      input logic [2:0] bl, input logic [1:0] mk, input logic [15:0] wd);
    @(negedge clk);
    if (k > 0) chk(k - 1);
    drive(rd, wr, stp, bl, mk, wd);
    k++;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) step(0, 0, 0, 3'd0, 2'b00, 16'h0000);
  endtask

  task automatic set_cl(input bit c3);
    focus = "latency switch";
    step(0, 0, 1, 3'd0, 2'b00, 16'h0000);
    idle(8);
    cas_lat3 = c3;
    cl = c3 ? 3 : 2;
  endtask

  task automatic directed();
    focus = "R2 R3 write burst";
    step(0, 1, 0, 3'd2, 2'b00, 16'h1111);
    step(0, 0, 0, 3'd0, 2'b01, 16'h2222);
    step(0, 0, 0, 3'd0, 2'b10, 16'h3333);
    step(0, 0, 0, 3'd0, 2'b11, 16'h4444);
    idle(3);
    focus = "R7 length latched";
    step(1, 0, 0, 3'd3, 2'b00, 16'h0);
    for (int j = 1; j < 8; j++) step(0, 0, 0, 3'd0, 2'(j), 16'h0);
    idle(6);
    focus = "R9 stop cuts read";
    step(1, 0, 0, 3'd3, 2'b00, 16'h0);
    step(0, 0, 0, 3'd0, 2'b01, 16'h0);
    step(0, 0, 0, 3'd0, 2'b10, 16'h0);
    step(0, 0, 1, 3'd0, 2'b00, 16'h0);
    idle(6);
    focus = "R8 back to back reads";
    step(1, 0, 0, 3'd0, 2'b10, 16'h0);
    step(1, 0, 0, 3'd0, 2'b01, 16'h0);
    step(1, 0, 0, 3'd1, 2'b11, 16'h0);
    idle(6);
    focus = "R8 priority";
    step(1, 1, 0, 3'd1, 2'b01, 16'hABCD);
    idle(3);
    step(1, 0, 0, 3'd7, 2'b00, 16'h0);
    idle(5);
    step(0, 1, 0, 3'd0, 2'b10, 16'h5555);
    idle(6);
    step(1, 0, 0, 3'd7, 2'b00, 16'h0);
    idle(10);
    step(1, 0, 1, 3'd0, 2'b00, 16'h0);
    idle(6);
    focus = "R9 stop ends endless burst";
    step(0, 0, 1, 3'd0, 2'b00, 16'h0);
    idle(6);
    focus = "R7 reserved code";
    step(1, 0, 0, 3'd5, 2'b00, 16'h0);
    idle(2);
    step(0, 1, 0, 3'd4, 2'b01, 16'h9876);
    idle(6);
  endtask

  task automatic rnd(input int n);
    focus = "random";
    for (int j = 0; j < n; j++) begin
      int r;
      bit rd, wr, stp;
      r = $urandom % 100;
      rd = 0; wr = 0; stp = 0;
      if (r < 6) wr = 1;
      else if (r < 14) rd = 1;
      else if (r < 19) stp = 1;
      step(rd, wr, stp, 3'($urandom % 8), 2'($urandom % 4), 16'($urandom));
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int j = 0; j < 16; j++) begin
      riss[j] = 0; wiss[j] = 0; msk[j] = 2'b00; wdat[j] = 16'h0;
    end
    rst_n = 1'b0; cas_lat3 = 1'b0; bl_code = 3'd0;
    rd_cmd = 0; wr_cmd = 0; stop_cmd = 0;
    beat_mask = 2'b00; wr_data = 16'h0; dq_in = 16'hC3C3;
    repeat (4) @(negedge clk);
    focus = "reset";
    cmp("R1 oe", {15'b0, dq_oe}, 16'd0);
    cmp("R1 mask", {14'b0, dqm_out}, 16'd0);
    cmp("R1 valid", {15'b0, rd_valid}, 16'd0);
    cmp("R1 last", {15'b0, rd_last}, 16'd0);
    cmp("R1 data", rd_data, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1 oe after release", {15'b0, dq_oe}, 16'd0);
    cmp("R1 valid after release", {15'b0, rd_valid}, 16'd0);
    for (int c = 0; c < 2; c++) begin
      set_cl(c == 1);
      directed();
      rnd(1500);
    end
    focus = "flush";
    step(0, 0, 1, 3'd0, 2'b00, 16'h0);
    idle(8);
    done = 1;
    summary();
    $finish;
  end

endmodule